// File: doc/BRIEF.md
# Bipolar Line Code Violation Counter

This block watches a dual-rail bipolar receive stream, one bit per enabled clock, and counts line code errors over fixed one-second windows. Each bit arrives as a positive-rail flag and a negative-rail flag, qualified by a bit-time strobe. An error is either a bipolar violation or, when enabled, a run of zeros that reaches a limit. With the zero-substitution mode enabled, the violation pair inside a valid substitution word is treated as legal line coding and is not counted.

Events add into a running 16-bit count that saturates at its maximum. A one-second tick copies the running count into a holding register and restarts the running count. The holding register is presented to the host as two bytes. The block keeps no framing state, and no synchronisation status affects counting: every enabled bit is always examined.

Top module: `lcv_monitor`

## Requirements
- R1: After a synchronous reset the holding register reads zero on both bytes, and the running count, polarity history, zero run and delay line are cleared.
- R2: A single-rail mark (rx_pos=1, rx_neg=0 means positive, rx_pos=0, rx_neg=1 means negative) is a bipolar violation when its polarity equals the polarity of the previous single-rail mark since reset. The first mark after reset is never a violation. A bit with both rails high counts as one violation, counts as a mark for the zero run, and leaves the remembered polarity unchanged.
- R3: With exz_en=0 and b8zs_en=0, only bipolar violations are counted.
- R4: With exz_en=1 and b8zs_en=0, each zero run that reaches 16 consecutive zero bits adds exactly one event, however long the run becomes. Any mark restarts the run.
- R5: With b8zs_en=1, a substitution word is eight bits 0,0,0,V,B,0,V,B. V repeats the polarity of the preceding mark, each B has the opposite polarity of the V just before it, and all four marks are single-rail. The two violations of such a word are not counted. With b8zs_en=0 they are counted.
- R6: With exz_en=1 and b8zs_en=1, the zero-run limit is 8 instead of 16, again one event per run.
- R7: On a cycle with sec_tick=1, the holding register takes the running count as it stood before that cycle, and the running count restarts from the events of that same cycle. Otherwise the holding register is unchanged. cnt_hi carries bits 15:8 and cnt_lo carries bits 7:0.
- R8: The running count stops at 65535 and never wraps.
- R9: Rail values on cycles with bit_en=0 are ignored. A bipolar violation enters the count on the fourth enabled bit after the bit that carried it, so that a substitution word can cancel it. Zero-run events enter the count on the bit that completes the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Marks a cycle carrying one received bit |
| rx_pos | input | 1 | Positive-rail mark for the current bit |
| rx_neg | input | 1 | Negative-rail mark for the current bit |
| exz_en | input | 1 | Enables counting of excessive zero runs |
| b8zs_en | input | 1 | Enables substitution-word exclusion and the 8-zero limit |
| sec_tick | input | 1 | One-second boundary strobe |
| cnt_hi | output | 8 | Holding register bits 15:8 |
| cnt_lo | output | 8 | Holding register bits 7:0 |

## Verification
The only view into the block is the holding register. Any fault in polarity tracking, the zero run or the delay line therefore shows up as a wrong total at the next tick, and no earlier. A stale polarity bit shifts the total by one. A miscounted run adds or drops one event. If the delay line is cleared at the wrong stage, a substitution word leaves one or three counts instead of zero. Timing faults in the four-bit delay show up only when a tick splits a violation from the bit that carried it, so the directed cases place the tick on exactly the cycle where the delayed event is counted.

// File: rtl/lcv_pkg.sv
package lcv_pkg;

    localparam int CNT_W      = 16;
    localparam int BYTE_W     = 8;
    localparam int CW_LEN     = 8;                 // substitution word length
    localparam int CW_FIRST_V = 4;                 // position of first V in word
    localparam int CW_DLY     = CW_LEN - CW_FIRST_V; // delay so both V's are cancellable
    localparam int ZLIM_PLAIN = 16;
    localparam int ZLIM_SUBST = 8;
    localparam int ZRUN_W     = $clog2(ZLIM_PLAIN + 1);

    typedef struct packed {
        logic pos;
        logic neg;
    } sym_t;

    function automatic logic sym_zero(sym_t s);
        return !s.pos && !s.neg;
    endfunction

    function automatic logic sym_single(sym_t s);
        return s.pos ^ s.neg;
    endfunction

    function automatic logic sym_both(sym_t s);
        return s.pos && s.neg;
    endfunction

endpackage

// File: rtl/lcv_bpv_track.sv
module lcv_bpv_track
    import lcv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  sym_t sym,
    output logic viol
);
    logic last_pos_q;
    logic seen_q;

    always_comb begin
        viol = bit_en && (sym_both(sym) ||
                          (sym_single(sym) && seen_q && (sym.pos == last_pos_q)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pos_q <= 1'b0;
            seen_q     <= 1'b0;
        end else if (bit_en && sym_single(sym)) begin
            last_pos_q <= sym.pos;
            seen_q     <= 1'b1;
        end
    end

    // Idle cycles must not disturb the polarity reference
    assert_idle_pol_R9: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(last_pos_q) && $stable(seen_q)));

endmodule

// File: rtl/lcv_subst_filter.sv
module lcv_subst_filter
    import lcv_pkg::*;
#(
    parameter int DLY = CW_DLY,
    parameter int HLEN = CW_LEN - 1
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic b8zs_en,
    input  sym_t sym,
    input  logic viol,
    output logic viol_out,
    output logic cw_hit
);
    logic [DLY-1:0]   d_q;
    logic [DLY-1:0]   d_nxt;
    sym_t [HLEN-1:0]  hist_q;
    logic             shape_ok;

    // hist_q[k] holds the bit received k+1 enabled bits ago; the current bit
    // is word position 8, so position p sits at index 7-p.
    always_comb begin
        shape_ok = sym_zero(hist_q[6]) && sym_zero(hist_q[5]) && sym_zero(hist_q[4])
                && sym_single(hist_q[3]) && sym_single(hist_q[2])
                && (hist_q[2].pos != hist_q[3].pos)
                && sym_zero(hist_q[1])
                && sym_single(hist_q[0]) && (hist_q[0].pos == hist_q[2].pos)
                && sym_single(sym) && (sym.pos != hist_q[0].pos);
        cw_hit   = bit_en && b8zs_en && shape_ok && d_q[DLY-1] && d_q[0];
        viol_out = bit_en && d_q[DLY-1] && !cw_hit;
        d_nxt    = {d_q[DLY-2:0], viol};
        if (cw_hit) d_nxt[1] = 1'b0;   // second V of the word, now moving to stage 1
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q    <= '0;
            hist_q <= '0;
        end else if (bit_en) begin
            d_q    <= d_nxt;
            hist_q <= {hist_q[HLEN-2:0], sym};
        end
    end

    assert_idle_dly_R9: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(d_q) && $stable(hist_q)));

    // Bit after a recognized word carries the word's B at stage DLY-1: never a violation
    assert_cw_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        cw_hit |=> !viol_out);

endmodule

// File: rtl/lcv_zero_run.sv
module lcv_zero_run
    import lcv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic exz_en,
    input  logic b8zs_en,
    input  sym_t sym,
    output logic zex
);
    localparam logic [ZRUN_W-1:0] LIM_PLAIN = ZRUN_W'(ZLIM_PLAIN);
    localparam logic [ZRUN_W-1:0] LIM_SUBST = ZRUN_W'(ZLIM_SUBST);

    logic [ZRUN_W-1:0] zrun_q;
    logic [ZRUN_W-1:0] lim;

    always_comb begin
        lim = b8zs_en ? LIM_SUBST : LIM_PLAIN;
        zex = bit_en && exz_en && sym_zero(sym) && (zrun_q == lim - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zrun_q <= '0;
        end else if (bit_en) begin
            if (!sym_zero(sym))  zrun_q <= '0;
            else if (zrun_q < lim) zrun_q <= zrun_q + 1'b1;
        end
    end

    // One event per run: a completed run cannot fire again on the next cycle
    assert_once_per_run_R4: assert property (@(posedge clk) disable iff (rst)
        zex |=> !zex);

endmodule

// File: rtl/lcv_accum.sv
module lcv_accum
    import lcv_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ev_a,
    input  logic         ev_b,
    input  logic         tick,
    output logic [W-1:0] hold
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] run_q;
    logic [1:0]   inc;
    logic [W:0]   sum;
    logic [W-1:0] run_sat;

    always_comb begin
        inc     = {1'b0, ev_a} + {1'b0, ev_b};
        sum     = {1'b0, run_q} + {{(W-1){1'b0}}, inc};
        run_sat = sum[W] ? MAXV : sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            hold  <= '0;
        end else if (tick) begin
            hold  <= run_q;
            run_q <= {{(W-2){1'b0}}, inc};
        end else begin
            run_q <= run_sat;
        end
    end

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (!tick && run_q == MAXV) |=> run_q == MAXV);

    assert_hold_steady_R7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(hold));

    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        tick |=> run_q <= W'(2));

endmodule

// File: rtl/lcv_monitor.sv
module lcv_monitor
    import lcv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       rx_pos,
    input  logic       rx_neg,
    input  logic       exz_en,
    input  logic       b8zs_en,
    input  logic       sec_tick,
    output logic [7:0] cnt_hi,
    output logic [7:0] cnt_lo
);
    sym_t             sym;
    logic             viol_now;
    logic             viol_dly;
    logic             cw_hit;
    logic             zex;
    logic [CNT_W-1:0] hold;

    assign sym = '{pos: rx_pos, neg: rx_neg};

    lcv_bpv_track u_track (
        .clk(clk), .rst(rst), .bit_en(bit_en), .sym(sym), .viol(viol_now)
    );

    lcv_subst_filter u_filter (
        .clk(clk), .rst(rst), .bit_en(bit_en), .b8zs_en(b8zs_en), .sym(sym),
        .viol(viol_now), .viol_out(viol_dly), .cw_hit(cw_hit)
    );

    lcv_zero_run u_zero (
        .clk(clk), .rst(rst), .bit_en(bit_en), .exz_en(exz_en), .b8zs_en(b8zs_en),
        .sym(sym), .zex(zex)
    );

    lcv_accum u_acc (
        .clk(clk), .rst(rst), .ev_a(viol_dly), .ev_b(zex), .tick(sec_tick), .hold(hold)
    );

    assign cnt_hi = hold[CNT_W-1:CNT_W-BYTE_W];
    assign cnt_lo = hold[BYTE_W-1:0];

    // A substitution word is only recognized in the substitution mode
    assert_cw_mode_R5: assert property (@(posedge clk) disable iff (rst)
        cw_hit |-> b8zs_en);

endmodule

// File: tb/lcv_monitor_tb.sv
`timescale 1ns/1ps
module lcv_monitor_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
    logic exz_en = 1'b0, b8zs_en = 1'b0, sec_tick = 1'b0;
    logic [7:0] cnt_hi, cnt_lo;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [1:0] stream[$];   // {pos,neg}
    logic blast;
    logic bseen;
    logic [15:0] lf;

    always #4 clk = ~clk;

    lcv_monitor u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .exz_en(exz_en), .b8zs_en(b8zs_en), .sec_tick(sec_tick),
        .cnt_hi(cnt_hi), .cnt_lo(cnt_lo)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input logic en, input logic p, input logic n, input logic tk);
        bit_en = en; rx_pos = p; rx_neg = n; sec_tick = tk;
        step();
        bit_en = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
    endtask

    function automatic int held();
        return {cnt_hi, cnt_lo};
    endfunction

    task automatic tick_read(output int v);
        put(1'b0, 1'b0, 1'b0, 1'b1);
        v = held();
    endtask

    // stream builders
    task automatic push(input logic [1:0] s);
        stream.push_back(s);
        if (s == 2'b10 || s == 2'b01) begin blast = s[1]; bseen = 1'b1; end
    endtask

    task automatic push_zeros(input int n);
        for (int i = 0; i < n; i++) push(2'b00);
    endtask

    task automatic push_flush();
        for (int i = 0; i < 4; i++) push(blast ? 2'b01 : 2'b10);
    endtask

    task automatic push_word();
        logic [1:0] v, b;
        if (!bseen) push(2'b10);
        v = blast ? 2'b10 : 2'b01;
        b = ~v;
        push_zeros(3); push(v); push(b); push(2'b00); push(b); push(v);
    endtask

    task automatic new_stream();
        stream.delete();
        blast = 1'b0;
        bseen = 1'b0;
    endtask

    function automatic logic one_rail(logic [1:0] s);
        return s == 2'b10 || s == 2'b01;
    endfunction

    // expected count computed from the requirement definitions
    function automatic int ref_count(input logic exz, input logic b8);
        int cnt = 0;
        int z = 0;
        int lim = b8 ? 8 : 16;
        logic last = 1'b0;
        logic seen = 1'b0;
        bit vf[$];
        for (int i = 0; i < stream.size(); i++) begin
            logic [1:0] s = stream[i];
            bit vi = 0;
            if (s == 2'b11) begin cnt++; vi = 1; z = 0; end
            else if (s != 2'b00) begin
                if (seen && s[1] == last) begin cnt++; vi = 1; end
                last = s[1]; seen = 1'b1; z = 0;
            end else if (z < lim) begin
                z++;
                if (exz && z == lim) cnt++;
            end
            vf.push_back(vi);
            if (b8 && i >= 7) begin
                if (stream[i-7] == 2'b00 && stream[i-6] == 2'b00 && stream[i-5] == 2'b00 &&
                    stream[i-2] == 2'b00 && one_rail(stream[i-4]) && one_rail(stream[i-3]) &&
                    one_rail(stream[i-1]) && one_rail(stream[i]) &&
                    stream[i-3] != stream[i-4] && stream[i-1] == stream[i-3] &&
                    stream[i] != stream[i-1] && vf[i-4])
                    cnt -= 2;
            end
        end
        return cnt;
    endfunction

    // reset, play stream (optionally with idle cycles carrying noise), tick, compare
    task automatic play(input logic exz, input logic b8, input string req,
                        input int exp, input bit idles);
        int got;
        int e;
        do_reset();
        exz_en = exz; b8zs_en = b8;
        foreach (stream[i]) begin
            put(1'b1, stream[i][1], stream[i][0], 1'b0);
            if (idles) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                if (lf[2:0] == 3'd0) put(1'b0, lf[5], lf[7], 1'b0);
            end
        end
        e = (exp >= 0) ? exp : ref_count(exz, b8);
        if (e > 65535) e = 65535;
        tick_read(got);
        check(req, got, e);
        tick_read(got);
        check({req, " R7 restart"}, got, 0);
    endtask

    task automatic build_random(input logic [15:0] seed, input int len);
        new_stream();
        lf = seed;
        for (int i = 0; i < len; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (i % 50 == 49) begin
                case ((i / 50) % 4)
                    0: push_word();
                    1: push_zeros(9);
                    2: push_zeros(17);
                    default: push_zeros(21);
                endcase
            end else if (lf[3:0] < 4'd8) push(2'b00);
            else if (lf[3:0] < 4'd11) push(2'b10);
            else if (lf[3:0] < 4'd15) push(2'b01);
            else push(2'b11);
        end
        push_flush();
    endtask

    initial begin
        int got;
        @(negedge clk);
        do_reset();
        check("R1 reset value", held(), 0);

        // R2: both-rail bit counts once, polarity kept
        new_stream(); push(2'b10); push(2'b11); push(2'b01); push_flush();
        play(1'b0, 1'b0, "R2 both rails", 1, 0);
        // R2: first mark never a violation; repeated polarity is
        new_stream(); push(2'b01); push(2'b01); push(2'b01); push_flush();
        play(1'b0, 1'b0, "R2 repeated polarity", 2, 0);

        // R5 vs R3: substitution word
        new_stream(); push(2'b10); push_word(); push_flush();
        play(1'b0, 1'b1, "R5 word excluded", 0, 0);
        new_stream(); push(2'b10); push_word(); push_flush();
        play(1'b0, 1'b0, "R3 word counted as BPV", 2, 0);
        new_stream(); push(2'b10); push_word(); push_flush();
        play(1'b1, 1'b1, "R6 word with zero limit 8", 0, 0);

        // R4 zero runs at 16
        new_stream(); push(2'b10); push_zeros(15); push_flush();
        play(1'b1, 1'b0, "R4 run of 15", 0, 0);
        new_stream(); push(2'b10); push_zeros(16); push_flush();
        play(1'b1, 1'b0, "R4 run of 16", 1, 0);
        new_stream(); push(2'b10); push_zeros(40); push_flush();
        play(1'b1, 1'b0, "R4 run of 40", 1, 0);
        new_stream(); push(2'b10); push_zeros(40); push_flush();
        play(1'b0, 1'b0, "R3 zeros ignored", 0, 0);
        // R6 zero runs at 8
        new_stream(); push(2'b10); push_zeros(7); push_flush();
        play(1'b1, 1'b1, "R6 run of 7", 0, 0);
        new_stream(); push(2'b10); push_zeros(8); push_flush();
        play(1'b1, 1'b1, "R6 run of 8", 1, 0);

        // R9: idle cycles carrying marks or zeros are ignored
        do_reset(); exz_en = 1'b0; b8zs_en = 1'b0;
        put(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) put(1'b0, 1'b1, 1'b0, 1'b0);
        put(1'b1, 1'b0, 1'b1, 1'b0); put(1'b1, 1'b1, 1'b0, 1'b0);
        put(1'b1, 1'b0, 1'b1, 1'b0); put(1'b1, 1'b1, 1'b0, 1'b0);
        tick_read(got);
        check("R9 idle marks ignored", got, 0);
        do_reset(); exz_en = 1'b1; b8zs_en = 1'b0;
        put(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 15; i++) put(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) put(1'b0, 1'b0, 1'b0, 1'b0);
        put(1'b1, 1'b0, 1'b1, 1'b0);
        tick_read(got);
        check("R9 idle zeros not in run", got, 0);

        // R9 latency: violation on bit 2 counted on bit 6
        do_reset(); exz_en = 1'b0; b8zs_en = 1'b0;
        put(1'b1, 1'b1, 1'b0, 1'b0); put(1'b1, 1'b1, 1'b0, 1'b0);
        put(1'b1, 1'b0, 1'b1, 1'b0); put(1'b1, 1'b1, 1'b0, 1'b0);
        tick_read(got);
        check("R9 violation still pending", got, 0);
        put(1'b1, 1'b0, 1'b1, 1'b0); put(1'b1, 1'b1, 1'b0, 1'b0);
        tick_read(got);
        check("R9 violation after four bits", got, 1);

        // R7: event counted on the tick cycle lands in the new interval
        do_reset();
        put(1'b1, 1'b1, 1'b0, 1'b0); put(1'b1, 1'b1, 1'b0, 1'b0);
        put(1'b1, 1'b0, 1'b1, 1'b0); put(1'b1, 1'b1, 1'b0, 1'b0);
        put(1'b1, 1'b0, 1'b1, 1'b0);
        put(1'b1, 1'b1, 1'b0, 1'b1);
        check("R7 tick-cycle event excluded", held(), 0);
        tick_read(got);
        check("R7 tick-cycle event in next interval", got, 1);

        // R7 byte split and R8 saturation
        new_stream(); for (int i = 0; i < 300; i++) push(2'b10);
        play(1'b0, 1'b0, "R7 byte split", 295, 0);
        do_reset();
        for (int i = 0; i < 70000; i++) put(1'b1, 1'b1, 1'b0, 1'b0);
        check("R7 hold unchanged before tick", held(), 0);
        put(1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 saturation hi byte", int'(cnt_hi), 255);
        check("R8 saturation lo byte", int'(cnt_lo), 255);

        // sweep every mode over several random streams (R3 R4 R5 R6 R2 R9)
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                build_random(16'hACE1 + 16'(s * 977 + m * 31), 260);
                play(m[0], m[1], $sformatf("R3/R4/R5/R6 sweep mode=%0d seed=%0d", m, s), -1, 1);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule